// File: doc/BRIEF.md
# Interleaved Operand Memory Loader

This block fills the operand memory of a modular exponentiation engine. Software or a DMA front end hands it one operand at a time: the exponent, the modulus or the message. Each operand arrives as a byte stream with a valid/ready handshake, most significant byte first. The block packs the bytes into 32-bit words and writes them through a single write port into a shared word memory. In that memory the three operands are interleaved in stripes of twelve words.

Each stored operand starts with its least significant word at logical word 0, so the block reverses the word order of the stream. For the exponent and the modulus it drops leading zero bytes and works out the exact bit length while the bytes pass through. A key length register downstream takes that figure. It zero-fills the message area past the supplied bytes up to the full message capacity. The operand code and the byte count are sampled on a start pulse. A done pulse closes every operation, including a rejected one.

Top module: `olx_operand_loader`

## Requirements
- R1: Logical word k of the exponent (operand code 0) is written at word address 12*(k/4) + k%4.
- R2: Logical word k of the modulus (operand code 1) is written at word address 12*(k/4) + k%4 + 4.
- R3: Logical word k of the message (operand code 2) is written at word address 12*(k/4) + k%4 + 8. Within each word the more significant byte sits in the higher byte lane (bits 31:24 hold the most significant of the four).
- R4: The last byte received is the least significant byte of logical word 0. Earlier bytes go to higher lanes and words. When the byte count is not a multiple of 4, the top word holds zeros in its unused high lanes.
- R5: For the exponent and the modulus, a word that holds only leading zero bytes (or lanes beyond the count) is not written. Exactly ceil(M/4) words are written, where M is the count left after stripping leading zeros.
- R6: For the exponent and the modulus, bit_len_o equals 8*M minus the number of leading zero bits in the first nonzero byte. An all-zero operand gives 0 and no writes. A message leaves bit_len_o at 0.
- R7: After the supplied message bytes, every remaining message word up to MSG_BYTES/4 words is written with zero. A message of length 0 writes only zero words.
- R8: An exponent or modulus longer than KEY_BYTES, a message longer than MSG_BYTES, or operand code 3 sets err_o. The block then writes nothing, keeps s_ready_o low and still issues done.
- R9: done_o is a one-cycle pulse that comes exactly one cycle after the last memory write of the operation, and never in a cycle with a write.
- R10: err_o and bit_len_o hold their values from the end of an operation until the next start, and a start clears both.
- R11: s_ready_o is high only while bytes of the current operand remain. Exactly byte_len_i bytes are taken, and bytes offered outside that window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins an operation; sampled only when idle |
| op_sel_i | input | 2 | Operand code: 0 exponent, 1 modulus, 2 message |
| byte_len_i | input | LEN_W | Number of bytes in the stream |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | 8 | Byte stream data, most significant byte first |
| s_ready_o | output | 1 | Byte stream ready |
| mem_we_o | output | 1 | Word write enable |
| mem_addr_o | output | ADDR_W | Word write address |
| mem_wdata_o | output | 32 | Word write data |
| done_o | output | 1 | End-of-operation pulse |
| err_o | output | 1 | Length or operand code rejected |
| bit_len_o | output | BL_W | Exact bit length of the last exponent or modulus |

## Verification
The bench builds the loader with KEY_BYTES=32, MSG_BYTES=64 and LEN_W=8. Both limits, the full message with no fill, and one byte past each limit can then be driven in tens of cycles, and the whole three-stripe memory stays small enough to check word by word after every run. The same settings let one run cover every partial top-word width, a fully stripped top word, and both the all-zero and the maximum-length bit-length cases.

// File: rtl/olx_pkg.sv
package olx_pkg;

    typedef enum logic [1:0] {
        OP_EXP = 2'd0,
        OP_MOD = 2'd1,
        OP_MSG = 2'd2,
        OP_BAD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_PAD    = 2'd2,
        ST_FIN    = 2'd3
    } st_e;

endpackage

// File: rtl/olx_stripe_map.sv
// Logical word index plus operand band to physical word address.
// Each stripe of 12 words holds 4 words per operand band.
module olx_stripe_map #(
    parameter int IDX_W  = 9,
    parameter int ADDR_W = 11
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [1:0]        band_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int STRIPE_W = IDX_W - 2;

    logic [STRIPE_W-1:0] stripe;

    always_comb begin
        stripe = idx_i[IDX_W-1:2];
        addr_o = ADDR_W'({stripe, 3'b000})
               + ADDR_W'({stripe, 2'b00})
               + ADDR_W'(idx_i[1:0])
               + ADDR_W'({band_i, 2'b00});
    end
endmodule

// File: rtl/olx_lead_zeros.sv
// Count of leading zero bits in one byte (8 for a zero byte).
module olx_lead_zeros #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CNT_W-1:0]  cnt_o
);
    always_comb begin
        cnt_o = CNT_W'(BYTE_W);
        for (int i = 0; i < BYTE_W; i++) begin
            if (byte_i[i]) cnt_o = CNT_W'(BYTE_W - 1 - i);
        end
    end
endmodule

// File: rtl/olx_operand_loader.sv
module olx_operand_loader
    import olx_pkg::*;
#(
    parameter int KEY_BYTES = 512,
    parameter int MSG_BYTES = 2048,
    parameter int LEN_W     = 16,
    localparam int MSG_WORDS = MSG_BYTES / 4,
    localparam int KEY_WORDS = KEY_BYTES / 4,
    localparam int WIDX_W    = $clog2(MSG_WORDS),
    localparam int ADDR_W    = $clog2(3 * MSG_WORDS),
    localparam int BL_W      = $clog2(8 * KEY_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_sel_i,
    input  logic [LEN_W-1:0]  byte_len_i,
    input  logic              s_valid_i,
    input  logic [7:0]        s_data_i,
    output logic              s_ready_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic              done_o,
    output logic              err_o,
    output logic [BL_W-1:0]   bit_len_o
);
    localparam logic [LEN_W-1:0]  KEY_LIM  = LEN_W'(KEY_BYTES);
    localparam logic [LEN_W-1:0]  MSG_LIM  = LEN_W'(MSG_BYTES);
    localparam logic [WIDX_W:0]   PAD_END  = (WIDX_W+1)'(MSG_WORDS);
    localparam logic [WIDX_W:0]   PAD_LAST = (WIDX_W+1)'(MSG_WORDS - 1);

    typedef struct packed {
        st_e               st;
        logic [1:0]        op;
        logic [LEN_W-1:0]  remain;
        logic [31:0]       acc;
        logic              seen;
        logic [WIDX_W:0]   pad_k;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic              done;
        logic              err;
        logic [BL_W-1:0]   blen;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0]  sig;
    logic [WIDX_W-1:0] map_idx;
    logic [ADDR_W-1:0] map_addr;
    logic [3:0]        lz;
    logic [LEN_W:0]    words_up;
    logic [LEN_W+3:0]  blen_full;
    logic              too_long;
    logic [31:0]       packed_word;
    logic              nz_now;

    assign sig     = q.remain - 1'b1;
    assign map_idx = (q.st == ST_PAD) ? q.pad_k[WIDX_W-1:0] : sig[WIDX_W+1:2];

    olx_stripe_map #(.IDX_W(WIDX_W), .ADDR_W(ADDR_W)) map_i (
        .idx_i  (map_idx),
        .band_i (q.op),
        .addr_o (map_addr)
    );

    olx_lead_zeros #(.BYTE_W(8), .CNT_W(4)) lz_i (
        .byte_i (s_data_i),
        .cnt_o  (lz)
    );

    always_comb begin
        words_up    = ({1'b0, byte_len_i} + (LEN_W+1)'(3)) >> 2;
        blen_full   = ({4'b0, q.remain} << 3) - (LEN_W+4)'(lz);
        packed_word = {q.acc[23:0], s_data_i};
        nz_now      = q.seen || (s_data_i != 8'h00);
        case (op_sel_i)
            OP_EXP, OP_MOD: too_long = byte_len_i > KEY_LIM;
            OP_MSG:         too_long = byte_len_i > MSG_LIM;
            default:        too_long = 1'b1;
        endcase

        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.err    = 1'b0;
                    d.blen   = '0;
                    d.op     = op_sel_i;
                    d.remain = byte_len_i;
                    d.acc    = '0;
                    d.seen   = 1'b0;
                    d.pad_k  = words_up[WIDX_W:0];
                    if (too_long) begin
                        d.err = 1'b1;
                        d.st  = ST_FIN;
                    end else if (byte_len_i == '0) begin
                        d.st = (op_sel_i == OP_MSG) ? ST_PAD : ST_FIN;
                    end else begin
                        d.st = ST_STREAM;
                    end
                end
            end
            ST_STREAM: begin
                if (s_valid_i) begin
                    d.acc    = packed_word;
                    d.remain = sig;
                    if (q.op != OP_MSG && !q.seen && s_data_i != 8'h00) begin
                        d.seen = 1'b1;
                        d.blen = blen_full[BL_W-1:0];
                    end
                    if (sig[1:0] == 2'b00 && (q.op == OP_MSG || nz_now)) begin
                        d.we    = 1'b1;
                        d.addr  = map_addr;
                        d.wdata = packed_word;
                    end
                    if (sig == '0) begin
                        d.st = (q.op == OP_MSG && q.pad_k != PAD_END) ? ST_PAD : ST_FIN;
                    end
                end
            end
            ST_PAD: begin
                d.we    = 1'b1;
                d.addr  = map_addr;
                d.wdata = '0;
                d.pad_k = q.pad_k + 1'b1;
                if (q.pad_k == PAD_LAST) d.st = ST_FIN;
            end
            default: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign s_ready_o   = (q.st == ST_STREAM);
    assign mem_we_o    = q.we;
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = q.wdata;
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign bit_len_o   = q.blen;

    // Band checks: the address produced by the map must land in the band of the operand in flight.
    assert_exp_band_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && q.op == OP_EXP) |-> (int'(mem_addr_o) % 12) < 4);
    assert_mod_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && q.op == OP_MOD) |-> ((int'(mem_addr_o) % 12) >= 4 && (int'(mem_addr_o) % 12) < 8));
    assert_msg_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && q.op == OP_MSG) |-> (int'(mem_addr_o) % 12) >= 8);
    assert_key_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && q.op != OP_MSG) |-> ((int'(mem_addr_o) / 12) * 4 + int'(mem_addr_o) % 4) < KEY_WORDS);
    assert_blen_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_len_o) <= 8 * KEY_BYTES);
    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!mem_we_o && !s_ready_o));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_we_o);
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(bit_len_o) && $stable(err_o)));
    assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !done_o);

endmodule

// File: tb/olx_operand_loader_tb_top.sv
module olx_operand_loader_tb_top;
    localparam int KEY_BYTES = 32;
    localparam int MSG_BYTES = 64;
    localparam int LEN_W     = 8;
    localparam int MSG_WORDS = MSG_BYTES / 4;
    localparam int KEY_WORDS = KEY_BYTES / 4;
    localparam int MEM_WORDS = 3 * MSG_WORDS;
    localparam int ADDR_W    = $clog2(MEM_WORDS);
    localparam int BL_W      = $clog2(8 * KEY_BYTES + 1);
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        op_sel_i = 2'd0;
    logic [LEN_W-1:0]  byte_len_i = '0;
    logic              s_valid_i = 1'b0;
    logic [7:0]        s_data_i = 8'h00;
    logic              s_ready_o;
    logic              mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [31:0]       mem_wdata_o;
    logic              done_o;
    logic              err_o;
    logic [BL_W-1:0]   bit_len_o;

    olx_operand_loader #(.KEY_BYTES(KEY_BYTES), .MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
        .byte_len_i(byte_len_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
        .s_ready_o(s_ready_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .done_o(done_o), .err_o(err_o), .bit_len_o(bit_len_o)
    );

    always #2 clk = ~clk;

    logic [31:0] mem [0:MEM_WORDS-1];
    logic [7:0]  src [0:127];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int last_wr_cyc = 0;
    int done_cnt = 0;
    int done_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mem_we_o) begin
            mem[mem_addr_o] = mem_wdata_o;
            wr_cnt = wr_cnt + 1;
            last_wr_cyc = cyc;
        end
        if (done_o) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    initial begin
        #400000;
        fails = fails + 1;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (act !== expv) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic fill_sentinel();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = SENT;
    endtask

    task automatic load_src(input int n, input int lead, input logic [7:0] first);
        for (int i = 0; i < n; i++) begin
            if (i < lead)       src[i] = 8'h00;
            else if (i == lead) src[i] = first;
            else                src[i] = 8'(i * 29 + 7);
        end
    endtask

    function automatic logic [31:0] ref_word(input int n, input int k);
        logic [31:0] w;
        int s;
        w = '0;
        for (int b = 0; b < 4; b++) begin
            s = 4 * k + 3 - b;
            w = {w[23:0], (s < n) ? src[n - 1 - s] : 8'h00};
        end
        return w;
    endfunction

    function automatic int ref_addr(input int band, input int k);
        return 12 * (k / 4) + (k % 4) + 4 * band;
    endfunction

    // Start an operation and stream n bytes; optional idle gaps on the valid line.
    task automatic run_op(input logic [1:0] op, input int n, input bit gaps);
        int i;
        int d0;
        fill_sentinel();
        wr_cnt = 0;
        d0 = done_cnt;
        @(negedge clk);
        start_i = 1'b1;
        op_sel_i = op;
        byte_len_i = LEN_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        i = 0;
        while (i < n) begin
            if (gaps && (cyc % 3 == 0)) begin
                s_valid_i = 1'b0;
            end else begin
                s_valid_i = 1'b1;
                s_data_i = src[i];
                if (s_ready_o) i = i + 1;
            end
            @(negedge clk);
        end
        s_valid_i = 1'b0;
        while (done_cnt == d0) @(negedge clk);
    endtask

    task automatic check_key(input string req, input int band, input int n);
        int lead;
        int m;
        int nw;
        int bits;
        int lzb;
        lead = 0;
        while (lead < n && src[lead] == 8'h00) lead = lead + 1;
        m = n - lead;
        nw = (m + 3) / 4;
        bits = 0;
        if (m > 0) begin
            lzb = 0;
            while (lzb < 8 && src[lead][7 - lzb] == 1'b0) lzb = lzb + 1;
            bits = 8 * m - lzb;
        end
        for (int k = 0; k < KEY_WORDS; k++)
            chk(req, mem[ref_addr(band, k)], (k < nw) ? ref_word(n, k) : SENT);
        chk({req, " R5 write count"}, 32'(wr_cnt), 32'(nw));
        chk({req, " R6 bit length"}, 32'(bit_len_o), 32'(bits));
        chk({req, " R8 err clear"}, 32'(err_o), 32'd0);
        if (nw > 0) chk({req, " R9 done timing"}, 32'(done_cyc), 32'(last_wr_cyc + 1));
    endtask

    task automatic check_msg(input string req, input int n);
        for (int k = 0; k < MSG_WORDS; k++)
            chk(req, mem[ref_addr(2, k)], ref_word(n, k));
        chk({req, " R7 write count"}, 32'(wr_cnt), 32'(MSG_WORDS));
        chk({req, " R6 msg bit length"}, 32'(bit_len_o), 32'd0);
        chk({req, " R9 done timing"}, 32'(done_cyc), 32'(last_wr_cyc + 1));
        for (int k = 0; k < MSG_WORDS; k++) begin
            chk({req, " R3 other bands untouched"}, mem[ref_addr(0, k)], SENT);
        end
    endtask

    // R11: after an operation, offered bytes are not taken and cause no writes.
    task automatic check_idle_bytes();
        int w0;
        w0 = wr_cnt;
        s_valid_i = 1'b1;
        s_data_i = 8'hA5;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R11 ready low when idle", 32'(s_ready_o), 32'd0);
        end
        s_valid_i = 1'b0;
        chk("R11 no write from stray bytes", 32'(wr_cnt), 32'(w0));
    endtask

    task automatic t_exp_small();
        load_src(3, 0, 8'h01);
        src[1] = 8'h00; src[2] = 8'h01;
        run_op(2'd0, 3, 1'b1);
        check_key("R1 R4 exponent 3 bytes", 0, 3);
        chk("R4 left padded word", mem[0], 32'h0001_0001);
        check_idle_bytes();
    endtask

    task automatic t_mod_lead();
        load_src(10, 2, 8'h35);
        run_op(2'd1, 10, 1'b0);
        check_key("R2 R5 modulus stripped", 1, 10);
        chk("R5 stripped top word untouched", mem[ref_addr(1, 2)], SENT);
    endtask

    task automatic t_mod_full();
        load_src(KEY_BYTES, 0, 8'h80);
        run_op(2'd1, KEY_BYTES, 1'b1);
        check_key("R2 R8 modulus at limit", 1, KEY_BYTES);
    endtask

    task automatic t_exp_odd();
        load_src(21, 1, 8'h0F);
        run_op(2'd0, 21, 1'b0);
        check_key("R1 R6 exponent two stripes", 0, 21);
    endtask

    task automatic t_key_zero();
        load_src(6, 6, 8'h00);
        run_op(2'd0, 6, 1'b0);
        check_key("R6 all-zero exponent", 0, 6);
    endtask

    task automatic t_reject(input string req, input logic [1:0] op, input int n);
        int d0;
        fill_sentinel();
        wr_cnt = 0;
        d0 = done_cnt;
        @(negedge clk);
        start_i = 1'b1;
        op_sel_i = op;
        byte_len_i = LEN_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        s_valid_i = 1'b1;
        s_data_i = 8'h5A;
        for (int c = 0; c < 4; c++) begin
            chk({req, " R8 no ready"}, 32'(s_ready_o), 32'd0);
            @(negedge clk);
        end
        s_valid_i = 1'b0;
        chk({req, " R8 done issued"}, 32'(done_cnt), 32'(d0 + 1));
        chk({req, " R8 err set"}, 32'(err_o), 32'd1);
        chk({req, " R8 no writes"}, 32'(wr_cnt), 32'd0);
        chk({req, " R8 bit length zero"}, 32'(bit_len_o), 32'd0);
    endtask

    task automatic t_msg(input string req, input int n);
        load_src(n, 0, 8'hC3);
        run_op(2'd2, n, n % 2 == 1);
        check_msg(req, n);
    endtask

    task automatic t_hold();
        logic [BL_W-1:0] bl;
        load_src(5, 0, 8'h2B);
        run_op(2'd1, 5, 1'b0);
        bl = bit_len_o;
        chk("R10 bit length before wait", 32'(bl), 32'd38);
        repeat (6) @(negedge clk);
        chk("R10 bit length held", 32'(bit_len_o), 32'(bl));
        t_reject("R10 reject after key", 2'd0, KEY_BYTES + 1);
        repeat (5) @(negedge clk);
        chk("R10 err held", 32'(err_o), 32'd1);
        load_src(4, 0, 8'h01);
        run_op(2'd0, 4, 1'b0);
        chk("R10 start clears err", 32'(err_o), 32'd0);
        chk("R10 new bit length", 32'(bit_len_o), 32'd25);
    endtask

    initial begin
        fill_sentinel();
        repeat (3) @(negedge clk);
        chk("R11 reset ready", 32'(s_ready_o), 32'd0);
        chk("R9 reset done", 32'(done_o), 32'd0);
        chk("R8 reset err", 32'(err_o), 32'd0);
        chk("R6 reset bit length", 32'(bit_len_o), 32'd0);
        chk("R9 reset write", 32'(mem_we_o), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        t_exp_small();
        t_mod_lead();
        t_mod_full();
        t_exp_odd();
        t_key_zero();
        t_reject("R8 exponent over", 2'd0, KEY_BYTES + 1);
        t_reject("R8 modulus over", 2'd1, KEY_BYTES + 7);
        t_reject("R8 message over", 2'd2, MSG_BYTES + 1);
        t_reject("R8 bad code", 2'd3, 4);
        t_msg("R3 R7 message 7 bytes", 7);
        t_msg("R7 message empty", 0);
        t_msg("R3 R4 message full", MSG_BYTES);
        t_msg("R3 R7 message 22 bytes", 22);
        t_hold();
        check_idle_bytes();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule